// File: doc/BRIEF.md
# Serial Audio Digital Loopback Router

This block sits between the serial audio ports and the converter data paths of an audio codec. It decides what the DAC data path consumes. Normally it takes left/right sample pairs from the serial input port. When software asks for loopback, it takes the pairs captured by the ADC instead. Entry to and exit from loopback are aligned to frame starts, so a pair is always forwarded whole. Samples are never split or mixed across channels.

The block also holds one control register. That register carries the loopback request, a 2-bit DAC interface-format field and a 1-bit ADC interface-format field. While loopback is active, the DAC format seen by the DAC port is frozen. New writes to the DAC field are kept in the register, and they take effect only on the cycle loopback ends. The format select for the serial data output always follows the ADC format field, and that includes the time spent in loopback.

All three sample interfaces use valid/ready handshakes. A pair moves when valid and ready are both high at a clock edge. The DAC output holds its pair steady while ready is low. The selected source sees back-pressure from the output register. The unselected source is always ready and its pairs are discarded.

Top module: `lbr_top`

## Requirements
- R1: After reset, loopback is off, the effective DAC format and the serial-output format are 0, and `dac_valid` is low.
- R2: A write with `ctl_we` high and `ctl_addr` equal to 4 loads the register from `ctl_wdata`. Bit 0 is the loopback request, bits 2:1 are the DAC format and bit 3 is the ADC format. A write to any other address changes nothing.
- R3: The loopback state takes the request value only at a clock edge where `frame_start` is high. A request written earlier has no effect on routing until that edge.
- R4: Outside loopback, the DAC output carries the serial-port pairs in arrival order. `adc_ready` stays high and ADC pairs are discarded.
- R5: In loopback, the DAC output carries the ADC pairs in arrival order. `sp_ready` stays high and serial-port pairs are discarded.
- R6: Each forwarded pair keeps its channel identity: input left appears on `dac_left` and input right appears on `dac_right`, in the same transfer.
- R7: While loopback is active, `dac_fmt` keeps the value it had when loopback was entered. DAC-field writes in that time are stored but do not change it.
- R8: In the first cycle after loopback ends, `dac_fmt` equals the DAC format field currently stored in the register.
- R9: `sdo_fmt` equals the stored ADC format field in every mode, one cycle after the write.
- R10: While `dac_valid` is high and `dac_ready` is low, `dac_valid` stays high and both output words stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctl_we | input | 1 | Control write strobe |
| ctl_addr | input | 3 | Control write address |
| ctl_wdata | input | 8 | Control write data |
| frame_start | input | 1 | One-cycle pulse at each frame boundary |
| adc_valid | input | 1 | ADC pair valid |
| adc_ready | output | 1 | ADC pair accepted |
| adc_left | input | 24 | ADC left sample |
| adc_right | input | 24 | ADC right sample |
| sp_valid | input | 1 | Serial-port pair valid |
| sp_ready | output | 1 | Serial-port pair accepted |
| sp_left | input | 24 | Serial-port left sample |
| sp_right | input | 24 | Serial-port right sample |
| dac_valid | output | 1 | DAC pair valid |
| dac_ready | input | 1 | DAC path can take a pair |
| dac_left | output | 24 | DAC left sample |
| dac_right | output | 24 | DAC right sample |
| dac_fmt | output | 2 | Effective DAC interface format |
| sdo_fmt | output | 1 | Serial-output format select |

## Verification
The routing is exercised with serial-port pairs and ADC pairs offered at the same time. This shows whether the source that was not selected is actually dropped instead of leaking into the DAC stream. A loopback request is written and data is sent before the frame pulse arrives. This separates routing that is aligned to the frame from routing that switches as soon as the register is written. The left and right words use different bit patterns, so a swapped channel is caught. The DAC sink stalls in an irregular pattern, which tests that data is held during back-pressure. DAC-field writes are made both inside and outside loopback, which separates a frozen format from one that tracks the register and from one that stays stuck after release.

// File: rtl/lbr_pkg.sv
package lbr_pkg;
  localparam int CTL_W   = 8;
  localparam int LB_BIT  = 0;
  localparam int DAC_LSB = 1;
  localparam int DAC_W   = 2;
  localparam int ADC_BIT = 3;

  typedef logic [DAC_W-1:0] dac_fmt_t;

  typedef struct packed {
    logic     adc_fmt;
    dac_fmt_t dac_fmt;
    logic     lb_req;
  } ctl_fields_t;

  function automatic ctl_fields_t decode_ctl(input logic [CTL_W-1:0] w);
    ctl_fields_t f;
    f.lb_req  = w[LB_BIT];
    f.dac_fmt = w[DAC_LSB +: DAC_W];
    f.adc_fmt = w[ADC_BIT];
    return f;
  endfunction
endpackage

// File: rtl/lbr_ctl.sv
module lbr_ctl
  import lbr_pkg::*;
#(
  parameter int ADDR_W   = 3,
  parameter int CTL_ADDR = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_we,
  input  logic [ADDR_W-1:0] ctl_addr,
  input  logic [CTL_W-1:0]  ctl_wdata,
  input  logic              frame_start,
  output logic              lb_active,
  output dac_fmt_t          dac_fmt_eff,
  output logic              sdo_fmt
);
  localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(CTL_ADDR);

  ctl_fields_t fields;
  dac_fmt_t    frozen_fmt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fields <= '0;
    end else if (ctl_we && ctl_addr == MY_ADDR) begin
      fields <= decode_ctl(ctl_wdata);
    end
  end

  // loopback state only moves at a frame boundary
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lb_active <= 1'b0;
    end else if (frame_start) begin
      lb_active <= fields.lb_req;
    end
  end

  // track the live field outside loopback; hold it once loopback is entered
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frozen_fmt <= '0;
    end else if (!lb_active) begin
      frozen_fmt <= fields.dac_fmt;
    end
  end

  assign dac_fmt_eff = lb_active ? frozen_fmt : fields.dac_fmt;
  assign sdo_fmt     = fields.adc_fmt;

  p_frame_switch_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(lb_active) |-> $past(frame_start));

  p_fmt_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (lb_active && $past(lb_active)) |-> $stable(dac_fmt_eff));

  p_release_fmt_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lb_active) |-> (dac_fmt_eff == fields.dac_fmt));
endmodule

// File: rtl/lbr_pair_mux.sv
module lbr_pair_mux #(
  parameter int DW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel_adc,
  input  logic          adc_valid,
  output logic          adc_ready,
  input  logic [DW-1:0] adc_left,
  input  logic [DW-1:0] adc_right,
  input  logic          sp_valid,
  output logic          sp_ready,
  input  logic [DW-1:0] sp_left,
  input  logic [DW-1:0] sp_right,
  output logic          dac_valid,
  input  logic          dac_ready,
  output logic [DW-1:0] dac_left,
  output logic [DW-1:0] dac_right
);
  localparam int NCH = 2;

  logic                    can_load;
  logic                    src_valid;
  logic                    take;
  logic [NCH-1:0][DW-1:0]  src_pair;
  logic [NCH-1:0][DW-1:0]  out_pair;

  assign can_load  = !dac_valid || dac_ready;
  assign src_valid = sel_adc ? adc_valid : sp_valid;
  assign take      = src_valid && can_load;
  assign adc_ready = sel_adc ? can_load : 1'b1;
  assign sp_ready  = sel_adc ? 1'b1 : can_load;

  // index 0 is left, index 1 is right
  assign src_pair[0] = sel_adc ? adc_left  : sp_left;
  assign src_pair[1] = sel_adc ? adc_right : sp_right;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dac_valid <= 1'b0;
    end else if (can_load) begin
      dac_valid <= src_valid;
    end
  end

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        out_pair[ch] <= '0;
      end else if (take) begin
        out_pair[ch] <= src_pair[ch];
      end
    end
  end

  assign dac_left  = out_pair[0];
  assign dac_right = out_pair[1];

  p_hold_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (dac_valid && !dac_ready) |=> (dac_valid && $stable(dac_left) && $stable(dac_right)));

  p_sp_drain_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sel_adc |-> sp_ready);

  p_adc_drain_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_adc |-> adc_ready);
endmodule

// File: rtl/lbr_top.sv
module lbr_top
  import lbr_pkg::*;
#(
  parameter int DW       = 24,
  parameter int ADDR_W   = 3,
  parameter int CTL_ADDR = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_we,
  input  logic [ADDR_W-1:0] ctl_addr,
  input  logic [7:0]        ctl_wdata,
  input  logic              frame_start,
  input  logic              adc_valid,
  output logic              adc_ready,
  input  logic [DW-1:0]     adc_left,
  input  logic [DW-1:0]     adc_right,
  input  logic              sp_valid,
  output logic              sp_ready,
  input  logic [DW-1:0]     sp_left,
  input  logic [DW-1:0]     sp_right,
  output logic              dac_valid,
  input  logic              dac_ready,
  output logic [DW-1:0]     dac_left,
  output logic [DW-1:0]     dac_right,
  output logic [1:0]        dac_fmt,
  output logic              sdo_fmt
);
  logic lb_active;

  lbr_ctl #(.ADDR_W(ADDR_W), .CTL_ADDR(CTL_ADDR)) u_ctl (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctl_we      (ctl_we),
    .ctl_addr    (ctl_addr),
    .ctl_wdata   (ctl_wdata),
    .frame_start (frame_start),
    .lb_active   (lb_active),
    .dac_fmt_eff (dac_fmt),
    .sdo_fmt     (sdo_fmt)
  );

  lbr_pair_mux #(.DW(DW)) u_mux (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel_adc   (lb_active),
    .adc_valid (adc_valid),
    .adc_ready (adc_ready),
    .adc_left  (adc_left),
    .adc_right (adc_right),
    .sp_valid  (sp_valid),
    .sp_ready  (sp_ready),
    .sp_left   (sp_left),
    .sp_right  (sp_right),
    .dac_valid (dac_valid),
    .dac_ready (dac_ready),
    .dac_left  (dac_left),
    .dac_right (dac_right)
  );
endmodule

// File: tb/lbr_top_tb.sv
module lbr_top_tb;
  localparam int DW = 24;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ctl_we = 1'b0;
  logic [2:0]    ctl_addr = '0;
  logic [7:0]    ctl_wdata = '0;
  logic          frame_start = 1'b0;
  logic          adc_valid = 1'b0;
  logic          adc_ready;
  logic [DW-1:0] adc_left = '0, adc_right = '0;
  logic          sp_valid = 1'b0;
  logic          sp_ready;
  logic [DW-1:0] sp_left = '0, sp_right = '0;
  logic          dac_valid;
  logic          dac_ready = 1'b0;
  logic [DW-1:0] dac_left, dac_right;
  logic [1:0]    dac_fmt;
  logic          sdo_fmt;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  bit stall_on = 0;
  logic [2*DW-1:0] sb_q[$];

  always #4 clk = ~clk;

  lbr_top u_dut (.*);

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: owns dac_ready, compares handed-over pairs with the scoreboard
  initial begin
    int cyc = 0;
    bit held = 0;
    logic [2*DW-1:0] held_pair = '0;
    forever begin
      @(negedge clk);
      cyc++;
      if (rst_n && held) begin
        check(dac_valid && {dac_left, dac_right} == held_pair, "R10",
              {dac_left, dac_right}, held_pair);
      end
      dac_ready = stall_on ? ((cyc % 3) != 0) : 1'b1;
      held = rst_n && dac_valid && !dac_ready;
      held_pair = {dac_left, dac_right};
      if (rst_n && dac_valid && dac_ready) begin
        if (sb_q.size() == 0) begin
          check(0, "R4/R5 unexpected pair", {dac_left, dac_right}, 0);
        end else begin
          logic [2*DW-1:0] e;
          e = sb_q.pop_front();
          check({dac_left, dac_right} == e, "R4/R5/R6 pair", {dac_left, dac_right}, e);
        end
      end
    end
  end

  task automatic reg_write(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    ctl_we = 1; ctl_addr = a; ctl_wdata = d;
    @(negedge clk);
    ctl_we = 0;
  endtask

  task automatic frame_pulse();
    @(negedge clk);
    frame_start = 1;
    @(negedge clk);
    frame_start = 0;
  endtask

  // offers one pair on each source at once; only the routed one is expected
  task automatic send_both(input logic [DW-1:0] sl, input logic [DW-1:0] sr,
                           input logic [DW-1:0] al, input logic [DW-1:0] ar, input bit lb);
    bit sp_done = 0, adc_done = 0;
    @(negedge clk);
    sp_valid = 1; sp_left = sl; sp_right = sr;
    adc_valid = 1; adc_left = al; adc_right = ar;
    while (!(sp_done && adc_done)) begin
      #3;
      if (sp_valid && sp_ready) begin
        sp_done = 1;
        if (!lb) sb_q.push_back({sl, sr});
      end
      if (adc_valid && adc_ready) begin
        adc_done = 1;
        if (lb) sb_q.push_back({al, ar});
      end
      @(negedge clk);
      if (sp_done) sp_valid = 0;
      if (adc_done) adc_valid = 0;
    end
  endtask

  task automatic drain();
    int n = 0;
    while ((sb_q.size() != 0 || dac_valid) && n < 200) begin
      @(negedge clk);
      n++;
    end
    check(sb_q.size() == 0, "R4/R5 drain", sb_q.size(), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check(dac_valid == 0, "R1 dac_valid", dac_valid, 0);
    check(dac_fmt == 0, "R1 dac_fmt", dac_fmt, 0);
    check(sdo_fmt == 0, "R1 sdo_fmt", sdo_fmt, 0);
    check(adc_ready == 1, "R1 not in loopback", adc_ready, 1);

    // R2 / R9: DAC field = 2 (bits 2:1), ADC field = 1 (bit 3)
    reg_write(3'd4, 8'b0000_1100);
    check(dac_fmt == 2'd2, "R2 dac_fmt", dac_fmt, 2);
    check(sdo_fmt == 1'b1, "R9 sdo_fmt", sdo_fmt, 1);
    reg_write(3'd5, 8'b0000_0011);
    check(dac_fmt == 2'd2, "R2 other address", dac_fmt, 2);
    check(sdo_fmt == 1'b1, "R2 other address sdo", sdo_fmt, 1);

    // R4 / R6: normal mode, serial-port pairs routed, with stalls
    stall_on = 1;
    for (int i = 0; i < 6; i++)
      send_both(24'hA00000 + DW'(i), 24'h500000 + DW'(i), 24'hC00000 + DW'(i), 24'h300000 + DW'(i), 0);
    drain();

    // R3: loopback requested, no frame pulse yet -> still serial-port routing
    reg_write(3'd4, 8'b0000_1101);
    repeat (3) @(negedge clk);
    check(adc_ready == 1, "R3 adc still drained", adc_ready, 1);
    send_both(24'hA11111, 24'h511111, 24'hC11111, 24'h311111, 0);
    drain();
    frame_pulse();

    // R5: loopback routes ADC pairs, serial port drained
    for (int i = 0; i < 6; i++)
      send_both(24'hA20000 + DW'(i), 24'h520000 + DW'(i), 24'hC20000 + DW'(i), 24'h320000 + DW'(i), 1);
    drain();
    stall_on = 0;
    @(negedge clk);
    check(sp_ready == 1, "R5 sp drained", sp_ready, 1);

    // R7: DAC field write during loopback has no effect; R9 ADC field still follows
    reg_write(3'd4, 8'b0000_0011);
    check(dac_fmt == 2'd2, "R7 dac_fmt frozen", dac_fmt, 2);
    check(sdo_fmt == 1'b0, "R9 sdo_fmt in loopback", sdo_fmt, 0);
    reg_write(3'd4, 8'b0000_0101);
    check(dac_fmt == 2'd2, "R7 dac_fmt frozen 2", dac_fmt, 2);

    // R8: release, DAC field = 1 still stored with loopback request cleared
    reg_write(3'd4, 8'b0000_0010);
    check(dac_fmt == 2'd2, "R3 release waits for frame", dac_fmt, 2);
    frame_pulse();
    check(dac_fmt == 2'd1, "R8 dac_fmt after release", dac_fmt, 1);
    check(adc_ready == 1, "R8 back to serial port", adc_ready, 1);

    // R4 again after release
    stall_on = 1;
    for (int i = 0; i < 4; i++)
      send_both(24'hA30000 + DW'(i), 24'h530000 + DW'(i), 24'hC30000 + DW'(i), 24'h330000 + DW'(i), 0);
    drain();

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule